// File: doc/BRIEF.md
# Unified Data-Space Address Decoder

This block sits between the data-side requesters of a small 8-bit microcontroller (the CPU and the DMA engine) and its physical memories. A 16-bit external-data request is steered to exactly one of five targets: on-chip SRAM, a 1 KB extended register file, a mirror of the 128-entry special-function register space, a 2 KB read-only information page, or a 32 KB read-only window into a larger banked flash. For the selected target it produces a one-hot select, the byte offset into that memory and a write enable. It also returns the read byte from whichever target answered. An 8-bit internal-data address is translated separately onto the topmost 256 bytes of SRAM.

The block owns the memory-control register. Its low three bits pick which 32 KB flash bank appears in the upper half of the external-data space. The register is reached through its own slot in the special-register mirror, and that slot is answered inside this block. Some special registers live inside the CPU core. Those are hidden from the mirror: they read as zero, and writes to them do not reach the special-register file. Reads from holes in the map and from a flash bank beyond the fitted flash size also return zero. Writes to read-only targets raise no select and no write enable.

Top module: `dspace_decoder`

## Requirements
- R1: An external-data address below SRAM_BYTES selects SRAM (region_sel bit 0) with phys_addr equal to the address, and a write there asserts mem_we.
- R2: Addresses 0x6000 to 0x63FF select the extended register file (region_sel bit 1) with phys_addr = address − 0x6000.
- R3: Addresses 0x7080 to 0x70FF select the special-register file (region_sel bit 2) with phys_addr = 0x80 + (address − 0x7080), except for hidden entries and the control-register slot.
- R4: A mirror entry whose bit is set in SFR_HIDE (bit k stands for special register 0x80+k) raises no select and no write enable, and reads as 0x00.
- R5: Reads at 0x7800 to 0x7FFF select the information page (region_sel bit 3) with phys_addr = address − 0x7800. Writes there raise no select and no mem_we.
- R6: Reads at 0x8000 to 0xFFFF select flash (region_sel bit 4) with phys_addr = bank × 0x8000 + (address − 0x8000), where bank is bits [2:0] of the control register. Writes there raise no select and no mem_we.
- R7: When the bank field is not below FLASH_BANKS, reads of the flash window raise no select and return 0x00.
- R8: Internal-data address d gives dp_sram_addr = SRAM_BYTES − 256 + d.
- R9: Any other external-data address raises no select and no mem_we, and reads as 0x00.
- R10: The control register sits at address 0x7000 + CTL_SFR, resets to 0x00, and reads back all eight bits as written. A write to it governs accesses from the next clock cycle on.
- R11: At most one bit of region_sel is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xd_addr | input | 16 | External-data address |
| xd_rd | input | 1 | External-data read strobe |
| xd_wr | input | 1 | External-data write strobe |
| xd_wdata | input | 8 | External-data write byte |
| xd_rdata | output | 8 | External-data read byte |
| region_sel | output | 5 | One-hot target: SRAM, ext regs, special regs, info page, flash |
| phys_addr | output | PA_W | Byte offset into the selected memory |
| mem_we | output | 1 | Write enable to the selected writable memory |
| sram_rdata | input | 8 | Read byte from SRAM |
| xreg_rdata | input | 8 | Read byte from the extended register file |
| sfr_rdata | input | 8 | Read byte from the special-register file |
| info_rdata | input | 8 | Read byte from the information page |
| flash_rdata | input | 8 | Read byte from flash |
| dp_addr | input | 8 | Internal-data address |
| dp_sram_addr | output | SRAM_AW | SRAM address for the internal-data port |

## Verification
The bench builds the block with 8 KB of SRAM and four flash banks. With that setting, SRAM ends well below the register area, so the gap between them can be probed as unassigned space. Bank values 4 to 7 become out-of-range selections, which a full eight-bank build could never exercise. The highest valid bank, 3, checks the top of the 17-bit flash address, and the internal-data alias lands on 0x1F00 to 0x1FFF.

// File: rtl/dsd_pkg.sv
// Shared constants for the data-space decoder.
// Assumes the fixed layout of the upper data space; only SRAM and flash sizes vary.
package dsd_pkg;
    localparam int RGN_N     = 5;
    localparam int RG_SRAM   = 0;
    localparam int RG_XREG   = 1;
    localparam int RG_SFR    = 2;
    localparam int RG_INFO   = 3;
    localparam int RG_FLASH  = 4;
    localparam int LOC_W     = 15;
    localparam int BANK_W    = 3;

    localparam logic [15:0] XREG_LO  = 16'h6000;
    localparam logic [15:0] XREG_HI  = 16'h63FF;
    localparam logic [15:0] MIR_LO   = 16'h7080;
    localparam logic [15:0] MIR_HI   = 16'h70FF;
    localparam logic [15:0] INFO_LO  = 16'h7800;
    localparam logic [15:0] INFO_HI  = 16'h7FFF;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/xdata_region_decode.sv
// Classifies an external-data address into one region and a local offset.
// Assumes SRAM_BYTES <= 0x6000 so SRAM never overlaps the register area.
// Outputs are raw address classes; access-type gating happens in the top.
module xdata_region_decode
    import dsd_pkg::*;
#(
    parameter int          SRAM_BYTES = 8192,
    parameter logic [127:0] SFR_HIDE  = 128'h0,
    parameter logic [7:0]  CTL_SFR    = 8'hC7
) (
    input  logic [15:0]       addr,
    output logic [RGN_N-1:0]  cls,
    output logic              ctl_hit,
    output logic              hid_hit,
    output logic [LOC_W-1:0]  loc
);
    localparam logic [15:0] CTL_ADDR = 16'h7000 + {8'h00, CTL_SFR};

    // Pick the address class and compute the offset inside it.
    always_comb begin
        cls     = '0;
        ctl_hit = 1'b0;
        hid_hit = 1'b0;
        loc     = '0;
        if (int'(addr) < SRAM_BYTES) begin
            cls[RG_SRAM] = 1'b1;
            loc          = addr[LOC_W-1:0];
        end else if (addr >= XREG_LO && addr <= XREG_HI) begin
            cls[RG_XREG] = 1'b1;
            loc          = {5'b0, addr[9:0]};
        end else if (addr >= MIR_LO && addr <= MIR_HI) begin
            if (addr == CTL_ADDR) begin
                ctl_hit = 1'b1;
            end else if (SFR_HIDE[addr[6:0]]) begin
                hid_hit = 1'b1;
            end else begin
                cls[RG_SFR] = 1'b1;
                loc         = {7'b0, 1'b1, addr[6:0]};
            end
        end else if (addr >= INFO_LO && addr <= INFO_HI) begin
            cls[RG_INFO] = 1'b1;
            loc          = {4'b0, addr[10:0]};
        end else if (addr[15]) begin
            cls[RG_FLASH] = 1'b1;
            loc           = addr[LOC_W-1:0];
        end
    end
endmodule

// File: rtl/flash_bank_map.sv
// Turns a window offset and bank number into a physical flash address.
// Assumes banks are 32 KB each and at most eight are present.
module flash_bank_map
    import dsd_pkg::*;
#(
    parameter int FLASH_BANKS = 8,
    localparam int FA_W = LOC_W + ((FLASH_BANKS > 1) ? $clog2(FLASH_BANKS) : 0)
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [LOC_W-1:0]  off,
    output logic [FA_W-1:0]   faddr,
    output logic              bank_ok
);
    logic [BANK_W+LOC_W-1:0] full;

    // Concatenate bank and offset, then keep the bits the fitted flash needs.
    always_comb begin
        full    = {bank, off};
        faddr   = full[FA_W-1:0];
        bank_ok = (int'(bank) < FLASH_BANKS);
    end
endmodule

// File: rtl/memctl_reg.sv
// Memory-control register: eight bits, bank field in [2:0].
// Assumes writes are single-cycle strobes; value is visible the cycle after.
module memctl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] q
);
    // Capture a written byte, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 8'h00;
        else if (wr_en) q <= wdata;
    end

    // R10
    memctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata)));
    // R10
    memctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/dspace_decoder.sv
// Data-space decoder top: steers external-data accesses to one physical memory,
// translates the flash window through the bank field, and aliases internal-data
// addresses onto the top 256 bytes of SRAM.
// Assumes read data from the memories arrives in the same cycle as the address,
// and that xd_rd and xd_wr are never high together.
module dspace_decoder
    import dsd_pkg::*;
#(
    parameter int           SRAM_BYTES  = 8192,
    parameter int           FLASH_BANKS = 8,
    parameter logic [127:0] SFR_HIDE    = (128'd1 << 1) | (128'd1 << 2) | (128'd1 << 3) |
                                          (128'd1 << 8'h50) | (128'd1 << 8'h60) | (128'd1 << 8'h70),
    parameter logic [7:0]   CTL_SFR     = 8'hC7,
    localparam int SRAM_AW = $clog2(SRAM_BYTES),
    localparam int FA_W    = LOC_W + ((FLASH_BANKS > 1) ? $clog2(FLASH_BANKS) : 0),
    localparam int PA_W    = imax(FA_W, imax(SRAM_AW, LOC_W))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        xd_addr,
    input  logic               xd_rd,
    input  logic               xd_wr,
    input  logic [7:0]         xd_wdata,
    output logic [7:0]         xd_rdata,
    output logic [RGN_N-1:0]   region_sel,
    output logic [PA_W-1:0]    phys_addr,
    output logic               mem_we,
    input  logic [7:0]         sram_rdata,
    input  logic [7:0]         xreg_rdata,
    input  logic [7:0]         sfr_rdata,
    input  logic [7:0]         info_rdata,
    input  logic [7:0]         flash_rdata,
    input  logic [7:0]         dp_addr,
    output logic [SRAM_AW-1:0] dp_sram_addr
);
    localparam logic [SRAM_AW-1:0] DP_BASE = SRAM_AW'(SRAM_BYTES - 256);

    logic [RGN_N-1:0] cls;
    logic             ctl_hit;
    logic             hid_hit;
    logic [LOC_W-1:0] loc;
    logic [7:0]       ctl_q;
    logic [FA_W-1:0]  faddr;
    logic             bank_ok;
    logic             acc;

    xdata_region_decode #(
        .SRAM_BYTES(SRAM_BYTES),
        .SFR_HIDE  (SFR_HIDE),
        .CTL_SFR   (CTL_SFR)
    ) i_dec (
        .addr   (xd_addr),
        .cls    (cls),
        .ctl_hit(ctl_hit),
        .hid_hit(hid_hit),
        .loc    (loc)
    );

    flash_bank_map #(.FLASH_BANKS(FLASH_BANKS)) i_fmap (
        .bank   (ctl_q[BANK_W-1:0]),
        .off    (loc),
        .faddr  (faddr),
        .bank_ok(bank_ok)
    );

    memctl_reg i_ctl (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(xd_wr && ctl_hit),
        .wdata(xd_wdata),
        .q    (ctl_q)
    );

    assign acc = xd_rd || xd_wr;

    // Gate each class by access type: read-only targets answer reads only.
    always_comb begin
        region_sel           = '0;
        region_sel[RG_SRAM]  = acc && cls[RG_SRAM];
        region_sel[RG_XREG]  = acc && cls[RG_XREG];
        region_sel[RG_SFR]   = acc && cls[RG_SFR];
        region_sel[RG_INFO]  = xd_rd && cls[RG_INFO];
        region_sel[RG_FLASH] = xd_rd && cls[RG_FLASH] && bank_ok;
    end

    // Write enable only for the writable targets.
    assign mem_we = xd_wr && (cls[RG_SRAM] || cls[RG_XREG] || cls[RG_SFR]);

    // Physical offset of the selected target, zero when nothing is selected.
    always_comb begin
        phys_addr = '0;
        if (region_sel[RG_FLASH])
            phys_addr = PA_W'(faddr);
        else if (region_sel[RG_SRAM] || region_sel[RG_XREG] ||
                 region_sel[RG_SFR]  || region_sel[RG_INFO])
            phys_addr = PA_W'(loc);
    end

    // Return the byte of the answering target, zero for holes and hidden entries.
    always_comb begin
        xd_rdata = 8'h00;
        if (xd_rd) begin
            if (ctl_hit)                   xd_rdata = ctl_q;
            else if (region_sel[RG_SRAM])  xd_rdata = sram_rdata;
            else if (region_sel[RG_XREG])  xd_rdata = xreg_rdata;
            else if (region_sel[RG_SFR])   xd_rdata = sfr_rdata;
            else if (region_sel[RG_INFO])  xd_rdata = info_rdata;
            else if (region_sel[RG_FLASH]) xd_rdata = flash_rdata;
        end
    end

    // Internal-data alias onto the top 256 SRAM bytes.
    assign dp_sram_addr = DP_BASE + SRAM_AW'(dp_addr);

    // R11
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_sel));
    // R5
    info_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xd_wr |-> !region_sel[RG_INFO]);
    // R6
    flash_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xd_wr |-> !region_sel[RG_FLASH]);
    // R7
    bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        region_sel[RG_FLASH] |-> (int'(ctl_q[BANK_W-1:0]) < FLASH_BANKS));
    // R4
    hidden_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hid_hit |-> (region_sel == '0 && !mem_we && xd_rdata == 8'h00));
    // R9
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xd_rd && region_sel == '0 && !ctl_hit) |-> (xd_rdata == 8'h00));
endmodule

// File: tb/test_dspace_decoder.sv
module test_dspace_decoder;
    localparam int PA = 17;
    localparam int SA = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   xd_addr = '0;
    logic          xd_rd = 1'b0, xd_wr = 1'b0;
    logic [7:0]    xd_wdata = '0;
    logic [7:0]    xd_rdata;
    logic [4:0]    region_sel;
    logic [PA-1:0] phys_addr;
    logic          mem_we;
    logic [7:0]    dp_addr = '0;
    logic [SA-1:0] dp_sram_addr;
    int            n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    dspace_decoder #(.SRAM_BYTES(8192), .FLASH_BANKS(4)) i_dspace_decoder (
        .clk(clk), .rst_n(rst_n),
        .xd_addr(xd_addr), .xd_rd(xd_rd), .xd_wr(xd_wr), .xd_wdata(xd_wdata),
        .xd_rdata(xd_rdata), .region_sel(region_sel), .phys_addr(phys_addr),
        .mem_we(mem_we),
        .sram_rdata(8'h11), .xreg_rdata(8'h22), .sfr_rdata(8'h33),
        .info_rdata(8'h44), .flash_rdata(8'h55),
        .dp_addr(dp_addr), .dp_sram_addr(dp_sram_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one access at the falling edge and settle before the next rise.
    task automatic acc(input logic [15:0] a, input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        xd_addr = a; xd_rd = r; xd_wr = w; xd_wdata = d;
        #1;
    endtask

    // addr, expected select, expected phys, expected read byte (bank 0)
    localparam int NV = 19;
    localparam logic [48:0] VEC [NV] = '{
        {16'h0000, 5'b00001, 20'h00000, 8'h11},   // R1
        {16'h1FFF, 5'b00001, 20'h01FFF, 8'h11},   // R1
        {16'h2000, 5'b00000, 20'h00000, 8'h00},   // R9
        {16'h5FFF, 5'b00000, 20'h00000, 8'h00},   // R9
        {16'h6000, 5'b00010, 20'h00000, 8'h22},   // R2
        {16'h63FF, 5'b00010, 20'h003FF, 8'h22},   // R2
        {16'h6400, 5'b00000, 20'h00000, 8'h00},   // R9
        {16'h707F, 5'b00000, 20'h00000, 8'h00},   // R9
        {16'h7080, 5'b00100, 20'h00080, 8'h33},   // R3
        {16'h70FF, 5'b00100, 20'h000FF, 8'h33},   // R3
        {16'h7081, 5'b00000, 20'h00000, 8'h00},   // R4
        {16'h70E0, 5'b00000, 20'h00000, 8'h00},   // R4
        {16'h7100, 5'b00000, 20'h00000, 8'h00},   // R9
        {16'h77FF, 5'b00000, 20'h00000, 8'h00},   // R9
        {16'h7800, 5'b01000, 20'h00000, 8'h44},   // R5
        {16'h7FFF, 5'b01000, 20'h007FF, 8'h44},   // R5
        {16'h8000, 5'b10000, 20'h00000, 8'h55},   // R6
        {16'hFFFF, 5'b10000, 20'h07FFF, 8'h55},   // R6
        {16'h70C7, 5'b00000, 20'h00000, 8'h00}    // R10 reset value
    };

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Table walk: reads with bank 0
        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][48:33], 1'b1, 1'b0, 8'h00);
            chk($sformatf("R1-table sel @%0h", VEC[i][48:33]), 32'(region_sel), 32'(VEC[i][32:28]));
            chk($sformatf("table phys @%0h", VEC[i][48:33]), 32'(phys_addr), 32'(VEC[i][27:8]));
            chk($sformatf("table rdata @%0h", VEC[i][48:33]), 32'(xd_rdata), 32'(VEC[i][7:0]));
            chk("R11 one-hot", 32'($countones(region_sel) <= 1), 32'd1);
        end

        // R1 write to SRAM
        acc(16'h0100, 1'b0, 1'b1, 8'hAB);
        chk("R1 sram we", {31'b0, mem_we}, 32'd1);
        chk("R1 sram sel", 32'(region_sel), 32'h01);
        // R2 write to ext regs
        acc(16'h6010, 1'b0, 1'b1, 8'hAB);
        chk("R2 xreg we", {31'b0, mem_we}, 32'd1);
        // R4 write to hidden entry
        acc(16'h7081, 1'b0, 1'b1, 8'hAB);
        chk("R4 hidden we", {31'b0, mem_we}, 32'd0);
        chk("R4 hidden sel", 32'(region_sel), 32'h00);
        // R5 write to info page
        acc(16'h7900, 1'b0, 1'b1, 8'hAB);
        chk("R5 info we", {31'b0, mem_we}, 32'd0);
        chk("R5 info sel", 32'(region_sel), 32'h00);
        // R6 write to flash window
        acc(16'h9000, 1'b0, 1'b1, 8'hAB);
        chk("R6 flash we", {31'b0, mem_we}, 32'd0);
        chk("R6 flash sel", 32'(region_sel), 32'h00);
        // R9 write to a hole
        acc(16'h2000, 1'b0, 1'b1, 8'hAB);
        chk("R9 hole we", {31'b0, mem_we}, 32'd0);

        // R10 control write is not a memory write; bank 2, upper bits set
        acc(16'h70C7, 1'b0, 1'b1, 8'hFA);
        chk("R10 ctl no we", {31'b0, mem_we}, 32'd0);
        acc(16'h8123, 1'b1, 1'b0, 8'h00);
        chk("R10 R6 next-cycle bank phys", 32'(phys_addr), 32'h10123);
        chk("R6 bank2 sel", 32'(region_sel), 32'h10);
        acc(16'h70C7, 1'b1, 1'b0, 8'h00);
        chk("R10 readback", 32'(xd_rdata), 32'hFA);

        // R7 bank 5 beyond four fitted banks
        acc(16'h70C7, 1'b0, 1'b1, 8'h05);
        acc(16'h8000, 1'b1, 1'b0, 8'h00);
        chk("R7 sel", 32'(region_sel), 32'h00);
        chk("R7 rdata", 32'(xd_rdata), 32'h00);
        // R7 bank 4 boundary
        acc(16'h70C7, 1'b0, 1'b1, 8'h04);
        acc(16'hFFFF, 1'b1, 1'b0, 8'h00);
        chk("R7 bank4 rdata", 32'(xd_rdata), 32'h00);
        // R6 top valid bank 3
        acc(16'h70C7, 1'b0, 1'b1, 8'h03);
        acc(16'hFFFF, 1'b1, 1'b0, 8'h00);
        chk("R6 bank3 phys", 32'(phys_addr), 32'h1FFFF);
        chk("R6 bank3 rdata", 32'(xd_rdata), 32'h55);

        // R8 internal-data alias
        acc(16'h0000, 1'b0, 1'b0, 8'h00);
        dp_addr = 8'h00; #1;
        chk("R8 dp low", 32'(dp_sram_addr), 32'h1F00);
        dp_addr = 8'hFF; #1;
        chk("R8 dp high", 32'(dp_sram_addr), 32'h1FFF);
        dp_addr = 8'h42; #1;
        chk("R8 dp mid", 32'(dp_sram_addr), 32'h1F42);

        // R10 reset clears the register
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        acc(16'h70C7, 1'b1, 1'b0, 8'h00);
        chk("R10 after reset", 32'(xd_rdata), 32'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule